// File: doc/BRIEF.md
# DRAM Request Classification Pipeline

This block sits at the entry of a DRAM controller and prepares each memory request for the scheduler. A request enters with an address and a read/write flag. The first stage slices the address into device, bank, row and column fields. The second stage reads a per-bank record of which banks hold an open row, and which row that is. From that record it labels the request as a row hit, an idle-bank access or a row conflict. These three labels mean a plain column access, an activate followed by an access, and a precharge, activate and access.

The third stage compares the request's bank and row with requests that are still in flight: the one sitting in the output stage and the last few that left the pipeline. A request that targets the same bank with a different row is flagged to be held back. Requests to other banks, or to the same open row, pass through unflagged, so work spread over several banks can proceed side by side. The record of open rows is kept up to date by the command issue logic. It reports each activate and precharge it sends, and a report made in the same cycle as a lookup of that bank is forwarded to the lookup.

Top module: `dram_req_classify`

## Requirements
- R1: With default parameters the address maps as column = addr[5:0], bank = addr[7:6], device = addr[8], row = addr[23:9]. Each field appears unchanged on the output together with the write flag.
- R2: `out_kind` is 0 (row hit) when the addressed device/bank has an open row equal to the request's row. Code 3 is never produced.
- R3: `out_kind` is 1 (bank idle) when the addressed device/bank has no open row. Reset leaves every bank without an open row.
- R4: `out_kind` is 2 (row conflict) when the addressed device/bank has an open row that differs from the request's row.
- R5: An update with `upd_act`=1 opens row `upd_row` in the named device/bank. An update with `upd_act`=0 closes it.
- R6: An update issued in the same cycle that a request to the same device/bank is classified takes effect for that request.
- R7: `out_hold` is 1 when the request's device and bank match, with a different row, either the request in the output stage or one of the last 4 requests that left the output. Otherwise it is 0, including for same-row matches and for requests older than the last 4.
- R8: A request accepted on a rising edge appears on the output after the third rising edge, counting the accepting edge. One request per cycle flows through, in order.
- R9: While `out_valid`=1 and `out_ready`=0 the output holds steady. When all three stages are full and stalled, `in_ready` is 0.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request taken on this edge when valid |
| in_addr | input | 24 | Request address |
| in_write | input | 1 | 1 for a write, 0 for a read |
| upd_valid | input | 1 | Open-row record update strobe |
| upd_act | input | 1 | 1 = activate (open), 0 = precharge (close) |
| upd_dev | input | 1 | Device of the update |
| upd_bank | input | 2 | Bank of the update |
| upd_row | input | 15 | Row opened by an activate |
| out_valid | output | 1 | Classified request available |
| out_ready | input | 1 | Downstream takes the request |
| out_kind | output | 2 | 0 row hit, 1 bank idle, 2 row conflict |
| out_hold | output | 1 | Same bank, different row in flight |
| out_dev | output | 1 | Device field |
| out_bank | output | 2 | Bank field |
| out_row | output | 15 | Row field |
| out_col | output | 6 | Column field |
| out_write | output | 1 | Write flag |

## Verification
Classification is tried against a bank that was never opened, a bank opened on the same row, a bank opened on another row, and a bank closed again after an activate. These cases separate all three labels and show that the record follows both kinds of update. A request whose bank is opened in the very cycle of its lookup shows whether the update is forwarded or the stale record is used. The conflict flag is tried with a same-bank different-row pair, a different-bank request, a same-row repeat and a request placed after four unrelated ones. These cases tell a true conflict apart from bank-only matching and show where the in-flight window ends. A burst with the output stalled, then released, shows stall stability, ordering and full throughput.

// File: rtl/dram_cls_pkg.sv
// Package: shared classification codes for the DRAM request pipeline.
// Assumes: the encoding below is part of the block's output contract.
package dram_cls_pkg;
    typedef enum logic [1:0] {
        PG_HIT      = 2'd0,
        PG_IDLE     = 2'd1,
        PG_CONFLICT = 2'd2
    } pg_kind_e;
endpackage

// File: rtl/dram_addr_split.sv
// Module: dram_addr_split
// Slices a flat request address into column, bank, device and row fields,
// in that order from the least significant bit upward.
// Assumes: ADDR_W exceeds COL_W + BANK_W + DEV_W; purely combinational.
module dram_addr_split #(
    parameter int ADDR_W = 24,
    parameter int DEV_W  = 1,
    parameter int BANK_W = 2,
    parameter int COL_W  = 6,
    localparam int ROW_W = ADDR_W - COL_W - BANK_W - DEV_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [DEV_W-1:0]  dev,
    output logic [ROW_W-1:0]  row
);
    localparam int BANK_LO = COL_W;
    localparam int DEV_LO  = COL_W + BANK_W;
    localparam int ROW_LO  = COL_W + BANK_W + DEV_W;

    // field extraction
    assign col  = addr[COL_W-1:0];
    assign bank = addr[BANK_LO +: BANK_W];
    assign dev  = addr[DEV_LO +: DEV_W];
    assign row  = addr[ROW_LO +: ROW_W];
endmodule

// File: rtl/dram_page_table.sv
// Module: dram_page_table
// Keeps, per device/bank, whether a row is open and which one; classifies a
// lookup as hit, idle or conflict. An update in the lookup cycle to the same
// entry is forwarded so the lookup sees the post-update state.
// Assumes: at most one update per cycle.
module dram_page_table
    import dram_cls_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int ROW_W = 15,
    localparam int NB   = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic             upd_act,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [ROW_W-1:0] upd_row,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [ROW_W-1:0] lk_row,
    output pg_kind_e         lk_kind
);
    logic [NB-1:0]    open_q;
    logic [ROW_W-1:0] row_q [NB];
    logic             eff_open;
    logic [ROW_W-1:0] eff_row;

    // open flags, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else if (upd_valid) open_q[upd_idx] <= upd_act;
    end

    // row numbers, written only on activate
    always_ff @(posedge clk) begin
        if (upd_valid && upd_act) row_q[upd_idx] <= upd_row;
    end

    // lookup with same-cycle forwarding
    always_comb begin
        eff_open = open_q[lk_idx];
        eff_row  = row_q[lk_idx];
        if (upd_valid && (upd_idx == lk_idx)) begin
            eff_open = upd_act;
            eff_row  = upd_row;
        end
        if (!eff_open)              lk_kind = PG_IDLE;
        else if (eff_row == lk_row) lk_kind = PG_HIT;
        else                        lk_kind = PG_CONFLICT;
    end

    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_act) |=> !open_q[$past(upd_idx)]); // R5
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_act) |=> (open_q[$past(upd_idx)] && row_q[$past(upd_idx)] == $past(upd_row))); // R5
endmodule

// File: rtl/dram_conflict_window.sv
// Module: dram_conflict_window
// Remembers the bank and row of the last DEPTH requests that left the pipeline
// and flags a probe that hits one of them, or the current output-stage entry,
// on the same bank with a different row.
// Assumes: push is the output handshake; cur_* is the output-stage entry.
module dram_conflict_window #(
    parameter int IDX_W = 3,
    parameter int ROW_W = 15,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic [ROW_W-1:0] push_row,
    input  logic             cur_v,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [ROW_W-1:0] cur_row,
    input  logic [IDX_W-1:0] probe_idx,
    input  logic [ROW_W-1:0] probe_row,
    output logic             conflict
);
    logic [DEPTH-1:0] hist_v;
    logic [IDX_W-1:0] hist_idx [DEPTH];
    logic [ROW_W-1:0] hist_row [DEPTH];
    logic [DEPTH-1:0] match;

    // valid bits of the history, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    hist_v <= '0;
        else if (push) hist_v <= {hist_v[DEPTH-2:0], 1'b1};
    end

    // history payload shifts on every departure
    always_ff @(posedge clk) begin
        if (push) begin
            hist_idx[0] <= push_idx;
            hist_row[0] <= push_row;
            for (int i = 1; i < DEPTH; i++) begin
                hist_idx[i] <= hist_idx[i-1];
                hist_row[i] <= hist_row[i-1];
            end
        end
    end

    // per-entry same-bank different-row compare
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = hist_v[g] && (hist_idx[g] == probe_idx) && (hist_row[g] != probe_row);
    end

    // combine history and output-stage compare
    assign conflict = (|match) || (cur_v && (cur_idx == probe_idx) && (cur_row != probe_row));

    AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (hist_v[0] && hist_idx[0] == $past(push_idx))); // R7
endmodule

// File: rtl/dram_req_classify.sv
// Module: dram_req_classify (top)
// Three-stage valid/ready pipeline: stage 1 holds the split address, stage 2
// the open-row classification, stage 3 the bank-conflict flag and drives the
// output. Each stage advances when the one after it is empty or moving.
// Assumes: update strobes come from the command issue logic.
module dram_req_classify
    import dram_cls_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DEV_W  = 1,
    parameter int BANK_W = 2,
    parameter int COL_W  = 6,
    parameter int DEPTH  = 4,
    localparam int ROW_W = ADDR_W - COL_W - BANK_W - DEV_W,
    localparam int IDX_W = DEV_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_write,
    input  logic              upd_valid,
    input  logic              upd_act,
    input  logic [DEV_W-1:0]  upd_dev,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic              out_hold,
    output logic [DEV_W-1:0]  out_dev,
    output logic [BANK_W-1:0] out_bank,
    output logic [ROW_W-1:0]  out_row,
    output logic [COL_W-1:0]  out_col,
    output logic              out_write
);
    logic [COL_W-1:0]  a_col;
    logic [BANK_W-1:0] a_bank;
    logic [DEV_W-1:0]  a_dev;
    logic [ROW_W-1:0]  a_row;

    logic              s1_v, s2_v, s3_v;
    logic [IDX_W-1:0]  s1_idx, s2_idx, s3_idx;
    logic [ROW_W-1:0]  s1_row, s2_row, s3_row;
    logic [COL_W-1:0]  s1_col, s2_col, s3_col;
    logic              s1_w, s2_w, s3_w;
    pg_kind_e          s2_kind, s3_kind, lk_kind;
    logic              s3_hold, win_conflict;
    logic              s1_rdy, s2_rdy, s3_rdy, out_fire;

    dram_addr_split #(.ADDR_W(ADDR_W), .DEV_W(DEV_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
        .addr(in_addr), .col(a_col), .bank(a_bank), .dev(a_dev), .row(a_row)
    );

    dram_page_table #(.IDX_W(IDX_W), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_act(upd_act),
        .upd_idx({upd_dev, upd_bank}), .upd_row(upd_row),
        .lk_idx(s1_idx), .lk_row(s1_row), .lk_kind(lk_kind)
    );

    dram_conflict_window #(.IDX_W(IDX_W), .ROW_W(ROW_W), .DEPTH(DEPTH)) u_window (
        .clk(clk), .rst_n(rst_n),
        .push(out_fire), .push_idx(s3_idx), .push_row(s3_row),
        .cur_v(s3_v), .cur_idx(s3_idx), .cur_row(s3_row),
        .probe_idx(s2_idx), .probe_row(s2_row), .conflict(win_conflict)
    );

    // stage advance conditions
    assign out_fire = s3_v && out_ready;
    assign s3_rdy   = !s3_v || out_ready;
    assign s2_rdy   = !s2_v || s3_rdy;
    assign s1_rdy   = !s1_v || s2_rdy;
    assign in_ready = s1_rdy;

    // stage valid bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s3_v <= 1'b0;
        end else begin
            if (s1_rdy) s1_v <= in_valid;
            if (s2_rdy) s2_v <= s1_v;
            if (s3_rdy) s3_v <= s2_v;
        end
    end

    // stage 1: capture the split address
    always_ff @(posedge clk) begin
        if (s1_rdy && in_valid) begin
            s1_idx <= {a_dev, a_bank};
            s1_row <= a_row;
            s1_col <= a_col;
            s1_w   <= in_write;
        end
    end

    // stage 2: capture the open-row classification
    always_ff @(posedge clk) begin
        if (s2_rdy && s1_v) begin
            s2_idx  <= s1_idx;
            s2_row  <= s1_row;
            s2_col  <= s1_col;
            s2_w    <= s1_w;
            s2_kind <= lk_kind;
        end
    end

    // stage 3: capture the bank-conflict flag
    always_ff @(posedge clk) begin
        if (s3_rdy && s2_v) begin
            s3_idx  <= s2_idx;
            s3_row  <= s2_row;
            s3_col  <= s2_col;
            s3_w    <= s2_w;
            s3_kind <= s2_kind;
            s3_hold <= win_conflict;
        end
    end

    // output drive
    assign out_valid = s3_v;
    assign out_kind  = s3_kind;
    assign out_hold  = s3_hold;
    assign out_dev   = s3_idx[IDX_W-1:BANK_W];
    assign out_bank  = s3_idx[BANK_W-1:0];
    assign out_row   = s3_row;
    assign out_col   = s3_col;
    assign out_write = s3_w;

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_kind, out_hold, out_dev, out_bank, out_row, out_col, out_write}))); // R9
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 2'd3)); // R2
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s2_v && s3_v && !out_ready) |-> !in_ready); // R9
    AST_IN_TO_S1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> s1_v); // R8
endmodule

// File: tb/tb_dram_req_classify.sv
module tb_dram_req_classify;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready, in_write = 1'b0;
    logic [23:0] in_addr = '0;
    logic        upd_valid = 1'b0, upd_act = 1'b0, upd_dev = 1'b0;
    logic [1:0]  upd_bank = '0;
    logic [14:0] upd_row = '0;
    logic        out_valid, out_ready = 1'b1, out_hold, out_dev, out_write;
    logic [1:0]  out_kind, out_bank;
    logic [14:0] out_row;
    logic [5:0]  out_col;
    int          n_chk = 0, n_fail = 0;
    int          lat;

    always #10 clk = ~clk;

    dram_req_classify dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_write(in_write), .upd_valid(upd_valid), .upd_act(upd_act),
        .upd_dev(upd_dev), .upd_bank(upd_bank), .upd_row(upd_row), .out_valid(out_valid),
        .out_ready(out_ready), .out_kind(out_kind), .out_hold(out_hold), .out_dev(out_dev),
        .out_bank(out_bank), .out_row(out_row), .out_col(out_col), .out_write(out_write)
    );

    function automatic logic [23:0] mk(input logic d, input logic [1:0] b, input logic [14:0] r, input logic [5:0] c);
        return {r, d, b, c};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; upd_valid = 1'b0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [23:0] a, input logic w);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; in_write = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect();
        lat = 1;
        do begin
            @(negedge clk);
            lat++;
        end while (!out_valid && lat < 20);
    endtask

    task automatic upd_cmd(input logic act, input logic d, input logic [1:0] b, input logic [14:0] r);
        @(negedge clk);
        upd_valid = 1'b1; upd_act = act; upd_dev = d; upd_bank = b; upd_row = r;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 out_valid after reset", out_valid, 0);
        check("R10 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_map_latency();
        do_reset();
        issue(mk(1'b1, 2'd2, 15'h5a3c, 6'h2d), 1'b1);
        collect();
        check("R8 latency", lat, 3);
        check("R1 dev", out_dev, 1);
        check("R1 bank", out_bank, 2);
        check("R1 row", out_row, 15'h5a3c);
        check("R1 col", out_col, 6'h2d);
        check("R1 write", out_write, 1);
        check("R3 idle after reset", out_kind, 1);
    endtask

    task automatic t_table();
        do_reset();
        upd_cmd(1'b1, 1'b0, 2'd1, 15'd5);
        issue(mk(1'b0, 2'd1, 15'd5, 6'd0), 1'b0);
        collect();
        check("R2 hit on open row", out_kind, 0);
        issue(mk(1'b0, 2'd1, 15'd9, 6'd0), 1'b0);
        collect();
        check("R4 conflict on other row", out_kind, 2);
        issue(mk(1'b1, 2'd1, 15'd5, 6'd0), 1'b0);
        collect();
        check("R3 other device idle", out_kind, 1);
        upd_cmd(1'b0, 1'b0, 2'd1, 15'd0);
        issue(mk(1'b0, 2'd1, 15'd5, 6'd0), 1'b0);
        collect();
        check("R5 precharge closes bank", out_kind, 1);
    endtask

    task automatic t_forward();
        do_reset();
        @(negedge clk);
        in_valid = 1'b1; in_addr = mk(1'b0, 2'd3, 15'd77, 6'd1); in_write = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        upd_valid = 1'b1; upd_act = 1'b1; upd_dev = 1'b0; upd_bank = 2'd3; upd_row = 15'd77;
        @(negedge clk);
        upd_valid = 1'b0;
        collect();
        check("R6 forwarded activate gives hit", out_kind, 0);
    endtask

    task automatic t_hold();
        do_reset();
        issue(mk(1'b0, 2'd1, 15'd5, 6'd0), 1'b0); collect();
        check("R7 first request no hold", out_hold, 0);
        issue(mk(1'b0, 2'd1, 15'd7, 6'd0), 1'b0); collect();
        check("R7 same bank other row holds", out_hold, 1);
        issue(mk(1'b0, 2'd2, 15'd7, 6'd0), 1'b0); collect();
        check("R7 other bank passes", out_hold, 0);
        issue(mk(1'b1, 2'd1, 15'd9, 6'd0), 1'b0); collect();
        check("R7 other device passes", out_hold, 0);
        for (int i = 0; i < 4; i++) begin
            issue(mk(1'b0, 2'd3, 15'd0, 6'd0), 1'b0); collect();
        end
        check("R7 same row repeat passes", out_hold, 0);
        issue(mk(1'b0, 2'd1, 15'd5, 6'd0), 1'b0); collect();
        check("R7 aged beyond window passes", out_hold, 0);
    endtask

    task automatic t_backpressure();
        do_reset();
        out_ready = 1'b0;
        for (int i = 1; i <= 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_addr = mk(1'b0, 2'd0, 15'd1, 6'(i)); in_write = 1'b0;
        end
        @(negedge clk);
        in_addr = mk(1'b0, 2'd0, 15'd1, 6'd4);
        #1;
        check("R9 in_ready low when full", in_ready, 0);
        check("R9 head while stalled", out_col, 1);
        @(negedge clk);
        check("R9 head stable", out_col, 1);
        check("R9 valid stable", out_valid, 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 order 2", out_col, 2);
        @(negedge clk);
        check("R8 order 3", out_col, 3);
        @(negedge clk);
        check("R8 order 4 back to back", out_col, 4);
        check("R8 valid on burst", out_valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_map_latency();
        t_table();
        t_forward();
        t_hold();
        t_backpressure();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule